// File: doc/BRIEF.md
# Load Queue with Squash Recovery

This block keeps the in-flight loads of an out-of-order core in program order. Each load enters at the tail with a sequence number. In the same cycle, the block returns the slot the load was given and a copy of the store-queue tail pointer. That copy lets later logic know which stores are older than the load. When the store queue is empty, a "no older store" flag is returned instead of an index. The ring has one more slot than its capacity, so full and empty are never confused.

Retirement frees entries from the head. While the commit request is held, up to `COMMIT_W` head entries per cycle are freed, as long as their sequence numbers do not exceed the supplied youngest-committed number. A squash request starts a backward walk from the newest entry. The walk removes one younger entry per cycle and holds a busy flag until it reaches an older entry or the ring is empty. A pending blocked-load marker is dropped by any squash that reaches back past it. The stored entries are exposed on flat buses so that neighbouring logic can scan them. The block also reports how many more memory operations can be dispatched, taking both queues into account.

Top module: `load_queue`

## Requirements
- R1: The queue holds at most `LQ_DEPTH` loads in `LQ_DEPTH+1` slots. `lq_count` never exceeds `LQ_DEPTH`. An insert while `lq_count == LQ_DEPTH` raises `ins_err` in that cycle and changes no state.
- R2: An accepted insert shows its slot on `ins_slot` (the current tail) in the same cycle. From the next cycle, that slot is valid and holds the load's sequence number. The tail advances by one and wraps from slot `LQ_DEPTH` to slot 0.
- R3: During an insert, `ins_st_none` is 1 and `ins_st_idx` is 0 when `st_count` is 0. Otherwise `ins_st_none` is 0 and `ins_st_idx` equals `st_tail`. Both values are stored with the entry and appear on `ent_st_none`/`ent_st_idx` at its slot.
- R4: While `cmt_valid` is held, each cycle frees up to `COMMIT_W` entries from the head, oldest first. Freeing stops at the first entry whose sequence number is greater than `cmt_seq`, and at an empty queue. Sequence numbers compare as unsigned values.
- R5: A `kill_req` latches `kill_seq` and raises `kill_busy` from the next cycle. In each following busy cycle, if the entry just before the tail has a sequence number greater than the latched number, that entry is freed and the tail steps back one slot (wrapping from 0 to `LQ_DEPTH`). Otherwise `kill_busy` falls at the next edge. A new `kill_req` restarts the walk with the new number.
- R6: Squash has priority. In a cycle with `kill_req` high or `kill_busy` high, commit frees nothing, and an insert is refused with `ins_err` high.
- R7: `blk_set` raises `blk_pending` and records `blk_seq`. A `kill_req` whose `kill_seq` is below the recorded number clears `blk_pending`; other squashes leave it set. When `blk_set` and such a `kill_req` occur in the same cycle, `blk_set` wins.
- R8: `free_cnt` equals the smaller of `LQ_DEPTH - lq_count` and `ST_DEPTH - st_count`.
- R9: `ent_valid` has exactly `lq_count` bits set. Each valid slot `i` carries its sequence number on `ent_seq[i*SEQ_W +: SEQ_W]`.
- R10: After reset, the queue is empty, `kill_busy` and `blk_pending` are 0, and all `ent_valid` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a load this cycle |
| ins_seq | input | SEQ_W | Sequence number of the inserted load |
| ins_slot | output | IDX_W | Slot assigned to the load (current tail) |
| ins_st_idx | output | ST_IDX_W | Store-queue tail copy for the load |
| ins_st_none | output | 1 | No store present at insert |
| ins_err | output | 1 | Insert refused (full or squash active) |
| st_tail | input | ST_IDX_W | Current store-queue tail index |
| st_count | input | ST_CNT_W | Stores currently held in the store queue |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| kill_req | input | 1 | Squash request |
| kill_seq | input | SEQ_W | Entries younger than this are removed |
| kill_busy | output | 1 | Squash walk in progress |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_pending | output | 1 | Blocked-load condition outstanding |
| lq_count | output | CNT_W | Loads held |
| free_cnt | output | FREE_W | Dispatch slots left across both queues |
| ent_valid | output | SLOTS | Per-slot valid bits |
| ent_seq | output | SLOTS*SEQ_W | Per-slot sequence numbers |
| ent_st_idx | output | SLOTS*ST_IDX_W | Per-slot store-tail copies |
| ent_st_none | output | SLOTS | Per-slot "no older store" flags |

## Verification
The bound checker watches several properties on every cycle:
- The occupancy bound, and that the population of `ent_valid` agrees with `lq_count`.
- That a refused insert never grows the queue, and that an accepted insert lands in its slot.
- That the free count never exceeds the load queue's own headroom, and that the no-store flag follows an empty store queue.
- That a squash walk removes at most one entry per cycle.

Some behaviours can only be shown by the bench's scenarios, because they depend on values across many cycles:
- Which entries a squash or commit actually removes, and where each walk stops.
- The wrap of head and tail past the last slot.
- The blocked-load clear decision.
- That commit stops at the first younger entry.

// File: rtl/lq_pkg.sv
package lq_pkg;

   typedef enum logic {
      KILL_IDLE = 1'b0,
      KILL_WALK = 1'b1
   } kill_state_e;

   // advance a ring index by k slots (k never exceeds the ring size)
   function automatic int ring_fwd(int idx, int k, int slots);
      int s;
      s = idx + k;
      if (s >= slots) s = s - slots;
      return s;
   endfunction

   // step a ring index back by one slot
   function automatic int ring_back(int idx, int slots);
      return (idx == 0) ? slots - 1 : idx - 1;
   endfunction

endpackage

// File: rtl/lq_entry_array.sv
module lq_entry_array #(
   parameter int SLOTS    = 9,
   parameter int SEQ_W    = 16,
   parameter int ST_IDX_W = 3,
   localparam int IDX_W   = $clog2(SLOTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [SEQ_W-1:0]          wr_seq,
   input  logic [ST_IDX_W-1:0]       wr_st_idx,
   input  logic                      wr_st_none,
   input  logic [SLOTS-1:0]          clr_mask,
   output logic [SLOTS-1:0]          valid_o,
   output logic [SLOTS*SEQ_W-1:0]    seq_o,
   output logic [SLOTS*ST_IDX_W-1:0] st_idx_o,
   output logic [SLOTS-1:0]          st_none_o
);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_o[i] <= 1'b0;
         end else if (clr_mask[i]) begin
            valid_o[i] <= 1'b0;
         end else if (hit) begin
            valid_o[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seq_o[i*SEQ_W +: SEQ_W]          <= '0;
            st_idx_o[i*ST_IDX_W +: ST_IDX_W] <= '0;
            st_none_o[i]                     <= 1'b1;
         end else if (hit) begin
            seq_o[i*SEQ_W +: SEQ_W]          <= wr_seq;
            st_idx_o[i*ST_IDX_W +: ST_IDX_W] <= wr_st_idx;
            st_none_o[i]                     <= wr_st_none;
         end
      end
   end

endmodule

// File: rtl/lq_commit_scan.sv
module lq_commit_scan #(
   parameter int SLOTS    = 9,
   parameter int DEPTH    = 8,
   parameter int COMMIT_W = 2,
   parameter int SEQ_W    = 16,
   localparam int IDX_W   = $clog2(SLOTS),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int RET_W   = $clog2(COMMIT_W + 1)
) (
   input  logic                   cmt_en,
   input  logic [IDX_W-1:0]       head,
   input  logic [CNT_W-1:0]       count,
   input  logic [SLOTS*SEQ_W-1:0] seq_flat,
   input  logic [SEQ_W-1:0]       cmt_seq,
   output logic [RET_W-1:0]       n_ret
);

   if (COMMIT_W == 1) begin : g_single
      logic [SEQ_W-1:0] head_seq;
      assign head_seq = seq_flat[int'(head)*SEQ_W +: SEQ_W];
      assign n_ret    = RET_W'(cmt_en && (count != '0) && (head_seq <= cmt_seq));
   end else begin : g_multi
      logic [COMMIT_W:0] run;
      assign run[0] = cmt_en;

      for (genvar k = 0; k < COMMIT_W; k++) begin : g_lane
         logic [IDX_W-1:0] slot_k;
         logic [SEQ_W-1:0] seq_k;
         assign slot_k   = IDX_W'(lq_pkg::ring_fwd(int'(head), k, SLOTS));
         assign seq_k    = seq_flat[int'(slot_k)*SEQ_W +: SEQ_W];
         assign run[k+1] = run[k] && (CNT_W'(k) < count) && (seq_k <= cmt_seq);
      end

      always_comb begin
         n_ret = '0;
         for (int k = 1; k <= COMMIT_W; k++) begin
            n_ret = n_ret + RET_W'(run[k]);
         end
      end
   end

endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl #(
   parameter int SLOTS    = 9,
   parameter int DEPTH    = 8,
   parameter int COMMIT_W = 2,
   parameter int SEQ_W    = 16,
   localparam int IDX_W   = $clog2(SLOTS),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int RET_W   = $clog2(COMMIT_W + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ins_valid,
   input  logic                   cmt_valid,
   input  logic                   kill_req,
   input  logic [SEQ_W-1:0]       kill_seq,
   input  logic                   blk_set,
   input  logic [SEQ_W-1:0]       blk_seq,
   input  logic [SLOTS*SEQ_W-1:0] seq_flat,
   input  logic [RET_W-1:0]       n_ret,
   output logic                   cmt_en,
   output logic                   ins_acc,
   output logic                   ins_err,
   output logic [IDX_W-1:0]       head,
   output logic [IDX_W-1:0]       tail,
   output logic [CNT_W-1:0]       count,
   output logic [SLOTS-1:0]       clr_mask,
   output logic                   kill_busy,
   output logic                   blk_pending
);

   lq_pkg::kill_state_e state, state_n;
   logic [SEQ_W-1:0] kill_num;
   logic [SEQ_W-1:0] blk_num;
   logic [IDX_W-1:0] last;
   logic [SEQ_W-1:0] last_seq;
   logic             walk, pop_now, idle_ok;
   logic [IDX_W-1:0] head_n, tail_n;
   logic [CNT_W-1:0] count_n;

   assign last     = IDX_W'(lq_pkg::ring_back(int'(tail), SLOTS));
   assign last_seq = seq_flat[int'(last)*SEQ_W +: SEQ_W];
   assign walk     = (state == lq_pkg::KILL_WALK) && !kill_req;
   assign pop_now  = walk && (count != '0) && (last_seq > kill_num);
   assign idle_ok  = (state == lq_pkg::KILL_IDLE) && !kill_req;
   assign ins_acc  = ins_valid && idle_ok && (count != CNT_W'(DEPTH));
   assign ins_err  = ins_valid && !ins_acc;
   assign cmt_en   = cmt_valid && idle_ok;
   assign kill_busy = (state == lq_pkg::KILL_WALK);

   always_comb begin
      state_n = state;
      if (kill_req)             state_n = lq_pkg::KILL_WALK;
      else if (walk && !pop_now) state_n = lq_pkg::KILL_IDLE;
   end

   always_comb begin
      head_n = IDX_W'(lq_pkg::ring_fwd(int'(head), int'(n_ret), SLOTS));
      if (ins_acc)      tail_n = IDX_W'(lq_pkg::ring_fwd(int'(tail), 1, SLOTS));
      else if (pop_now) tail_n = last;
      else              tail_n = tail;
      count_n = count + CNT_W'(ins_acc) - CNT_W'(n_ret) - CNT_W'(pop_now);
   end

   always_comb begin
      clr_mask = '0;
      for (int j = 0; j < COMMIT_W; j++) begin
         if (j < int'(n_ret)) clr_mask[lq_pkg::ring_fwd(int'(head), j, SLOTS)] = 1'b1;
      end
      if (pop_now) clr_mask[last] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= lq_pkg::KILL_IDLE;
         kill_num <= '0;
         head     <= '0;
         tail     <= '0;
         count    <= '0;
      end else begin
         state <= state_n;
         if (kill_req) kill_num <= kill_seq;
         head  <= head_n;
         tail  <= tail_n;
         count <= count_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_pending <= 1'b0;
         blk_num     <= '0;
      end else if (blk_set) begin
         blk_pending <= 1'b1;
         blk_num     <= blk_seq;
      end else if (kill_req && blk_pending && (kill_seq < blk_num)) begin
         blk_pending <= 1'b0;
      end
   end

endmodule

// File: rtl/load_queue.sv
module load_queue #(
   parameter int LQ_DEPTH = 8,
   parameter int ST_DEPTH = 6,
   parameter int SEQ_W    = 16,
   parameter int COMMIT_W = 2,
   localparam int SLOTS    = LQ_DEPTH + 1,
   localparam int IDX_W    = $clog2(SLOTS),
   localparam int CNT_W    = $clog2(LQ_DEPTH + 1),
   localparam int ST_IDX_W = $clog2(ST_DEPTH + 1),
   localparam int ST_CNT_W = $clog2(ST_DEPTH + 1),
   localparam int FREE_W   = $clog2(((LQ_DEPTH > ST_DEPTH) ? LQ_DEPTH : ST_DEPTH) + 1),
   localparam int RET_W    = $clog2(COMMIT_W + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ins_valid,
   input  logic [SEQ_W-1:0]          ins_seq,
   output logic [IDX_W-1:0]          ins_slot,
   output logic [ST_IDX_W-1:0]       ins_st_idx,
   output logic                      ins_st_none,
   output logic                      ins_err,
   input  logic [ST_IDX_W-1:0]       st_tail,
   input  logic [ST_CNT_W-1:0]       st_count,
   input  logic                      cmt_valid,
   input  logic [SEQ_W-1:0]          cmt_seq,
   input  logic                      kill_req,
   input  logic [SEQ_W-1:0]          kill_seq,
   output logic                      kill_busy,
   input  logic                      blk_set,
   input  logic [SEQ_W-1:0]          blk_seq,
   output logic                      blk_pending,
   output logic [CNT_W-1:0]          lq_count,
   output logic [FREE_W-1:0]         free_cnt,
   output logic [SLOTS-1:0]          ent_valid,
   output logic [SLOTS*SEQ_W-1:0]    ent_seq,
   output logic [SLOTS*ST_IDX_W-1:0] ent_st_idx,
   output logic [SLOTS-1:0]          ent_st_none
);

   if (LQ_DEPTH < 2) begin : g_bad_depth
      $error("load_queue: LQ_DEPTH must be at least 2");
   end
   if (ST_DEPTH < 1) begin : g_bad_st
      $error("load_queue: ST_DEPTH must be at least 1");
   end
   if (COMMIT_W < 1 || COMMIT_W > LQ_DEPTH) begin : g_bad_cw
      $error("load_queue: COMMIT_W must lie in 1..LQ_DEPTH");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("load_queue: SEQ_W must be at least 2");
   end

   logic             cmt_en, ins_acc;
   logic [IDX_W-1:0] head, tail;
   logic [SLOTS-1:0] clr_mask;
   logic [RET_W-1:0] n_ret;
   logic [FREE_W-1:0] lq_free, st_free;

   assign ins_slot    = tail;
   assign ins_st_none = (st_count == '0);
   assign ins_st_idx  = ins_st_none ? '0 : st_tail;

   assign lq_free  = FREE_W'(LQ_DEPTH) - FREE_W'(lq_count);
   assign st_free  = FREE_W'(ST_DEPTH) - FREE_W'(st_count);
   assign free_cnt = (lq_free < st_free) ? lq_free : st_free;

   lq_ctrl #(
      .SLOTS(SLOTS), .DEPTH(LQ_DEPTH), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .cmt_valid(cmt_valid),
      .kill_req(kill_req), .kill_seq(kill_seq),
      .blk_set(blk_set), .blk_seq(blk_seq),
      .seq_flat(ent_seq), .n_ret(n_ret),
      .cmt_en(cmt_en), .ins_acc(ins_acc), .ins_err(ins_err),
      .head(head), .tail(tail), .count(lq_count),
      .clr_mask(clr_mask), .kill_busy(kill_busy), .blk_pending(blk_pending)
   );

   lq_commit_scan #(
      .SLOTS(SLOTS), .DEPTH(LQ_DEPTH), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)
   ) u_scan (
      .cmt_en(cmt_en), .head(head), .count(lq_count),
      .seq_flat(ent_seq), .cmt_seq(cmt_seq), .n_ret(n_ret)
   );

   lq_entry_array #(
      .SLOTS(SLOTS), .SEQ_W(SEQ_W), .ST_IDX_W(ST_IDX_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ins_acc), .wr_idx(tail), .wr_seq(ins_seq),
      .wr_st_idx(ins_st_idx), .wr_st_none(ins_st_none),
      .clr_mask(clr_mask),
      .valid_o(ent_valid), .seq_o(ent_seq),
      .st_idx_o(ent_st_idx), .st_none_o(ent_st_none)
   );

endmodule

// File: rtl/load_queue_chk.sv
module load_queue_chk #(
   parameter int LQ_DEPTH = 8,
   parameter int ST_DEPTH = 6,
   parameter int SEQ_W    = 16,
   localparam int SLOTS    = LQ_DEPTH + 1,
   localparam int IDX_W    = $clog2(SLOTS),
   localparam int CNT_W    = $clog2(LQ_DEPTH + 1),
   localparam int ST_CNT_W = $clog2(ST_DEPTH + 1),
   localparam int FREE_W   = $clog2(((LQ_DEPTH > ST_DEPTH) ? LQ_DEPTH : ST_DEPTH) + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ins_valid,
   input logic              ins_err,
   input logic [IDX_W-1:0]  ins_slot,
   input logic              ins_st_none,
   input logic [ST_CNT_W-1:0] st_count,
   input logic              kill_req,
   input logic              kill_busy,
   input logic [CNT_W-1:0]  lq_count,
   input logic [FREE_W-1:0] free_cnt,
   input logic [SLOTS-1:0]  ent_valid
);

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lq_count) <= LQ_DEPTH); // R1

   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && int'(lq_count) == LQ_DEPTH) |-> ins_err); // R1

   AST_INS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !ins_err) |=> ent_valid[$past(ins_slot)]); // R2

   AST_NO_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && st_count == '0) |-> ins_st_none); // R3

   AST_WALK_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_busy && !kill_req) |=> (int'(lq_count) <= int'($past(lq_count)))
                                 && (int'(lq_count) + 1 >= int'($past(lq_count)))); // R5

   AST_REFUSED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      ins_err |=> int'(lq_count) <= int'($past(lq_count))); // R6

   AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_cnt) <= LQ_DEPTH - int'(lq_count)); // R8

   AST_VALID_POPULATION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ent_valid) == int'(lq_count)); // R9

endmodule

bind load_queue load_queue_chk #(
   .LQ_DEPTH(LQ_DEPTH), .ST_DEPTH(ST_DEPTH), .SEQ_W(SEQ_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_err(ins_err),
   .ins_slot(ins_slot), .ins_st_none(ins_st_none), .st_count(st_count),
   .kill_req(kill_req), .kill_busy(kill_busy), .lq_count(lq_count),
   .free_cnt(free_cnt), .ent_valid(ent_valid)
);

// File: tb/load_queue_bench.sv
module load_queue_bench;
   localparam int D    = 8;
   localparam int SD   = 6;
   localparam int SW   = 16;
   localparam int CW   = 2;
   localparam int S    = D + 1;
   localparam int IW   = $clog2(S);
   localparam int CNTW = $clog2(D + 1);
   localparam int SIW  = $clog2(SD + 1);
   localparam int SCW  = $clog2(SD + 1);
   localparam int FW   = $clog2(((D > SD) ? D : SD) + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0;
   logic [SW-1:0] ins_seq = '0;
   logic [IW-1:0] ins_slot;
   logic [SIW-1:0] ins_st_idx;
   logic ins_st_none, ins_err;
   logic [SIW-1:0] st_tail = '0;
   logic [SCW-1:0] st_count = '0;
   logic cmt_valid = 1'b0;
   logic [SW-1:0] cmt_seq = '0;
   logic kill_req = 1'b0;
   logic [SW-1:0] kill_seq = '0;
   logic kill_busy;
   logic blk_set = 1'b0;
   logic [SW-1:0] blk_seq = '0;
   logic blk_pending;
   logic [CNTW-1:0] lq_count;
   logic [FW-1:0] free_cnt;
   logic [S-1:0] ent_valid;
   logic [S*SW-1:0] ent_seq;
   logic [S*SIW-1:0] ent_st_idx;
   logic [S-1:0] ent_st_none;

   always #2 clk = ~clk;

   load_queue #(.LQ_DEPTH(D), .ST_DEPTH(SD), .SEQ_W(SW), .COMMIT_W(CW)) u_load_queue (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
      .ins_slot(ins_slot), .ins_st_idx(ins_st_idx), .ins_st_none(ins_st_none),
      .ins_err(ins_err), .st_tail(st_tail), .st_count(st_count),
      .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .kill_req(kill_req),
      .kill_seq(kill_seq), .kill_busy(kill_busy), .blk_set(blk_set),
      .blk_seq(blk_seq), .blk_pending(blk_pending), .lq_count(lq_count),
      .free_cnt(free_cnt), .ent_valid(ent_valid), .ent_seq(ent_seq),
      .ent_st_idx(ent_st_idx), .ent_st_none(ent_st_none)
   );

   // reference model state
   int m_head, m_tail, m_cnt, m_num, m_blkseq;
   bit m_busy, m_blk;
   bit m_val [S];
   int m_seq [S];
   int m_sti [S];
   bit m_stn [S];
   int next_seq = 100;
   int n_cmp = 0;
   int n_bad = 0;

   function automatic int min2(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_in();
      ins_valid = 0; cmt_valid = 0; kill_req = 0; blk_set = 0;
   endtask

   // inputs are set; check combinational outputs, advance the model, check state
   task automatic step();
      bit acc;
      int last;
      #1;
      acc = ins_valid && !m_busy && !kill_req && (m_cnt < D);
      chk("R1/R6 ins_err", ins_err, ins_valid && !acc);
      if (acc) chk("R2 ins_slot", ins_slot, m_tail);
      if (ins_valid) begin
         chk("R3 no-store flag", ins_st_none, st_count == 0);
         chk("R3 store tail copy", ins_st_idx, (st_count == 0) ? 0 : st_tail);
      end
      chk("R8 free_cnt", free_cnt, min2(D - m_cnt, SD - st_count));
      if (kill_req) begin
         if (m_blk && (kill_seq < m_blkseq)) m_blk = 0;
         m_busy = 1;
         m_num  = kill_seq;
      end else if (m_busy) begin
         last = (m_tail == 0) ? S - 1 : m_tail - 1;
         if (m_cnt > 0 && m_seq[last] > m_num) begin
            m_val[last] = 0; m_tail = last; m_cnt--;
         end else begin
            m_busy = 0;
         end
      end else begin
         if (cmt_valid) begin
            for (int k = 0; k < CW; k++) begin
               if (m_cnt > 0 && m_seq[m_head] <= int'(cmt_seq)) begin
                  m_val[m_head] = 0; m_head = (m_head + 1) % S; m_cnt--;
               end else break;
            end
         end
         if (acc) begin
            m_val[m_tail] = 1; m_seq[m_tail] = ins_seq;
            m_sti[m_tail] = (st_count == 0) ? 0 : st_tail;
            m_stn[m_tail] = (st_count == 0);
            m_tail = (m_tail + 1) % S; m_cnt++;
         end
      end
      if (blk_set) begin m_blk = 1; m_blkseq = blk_seq; end
      if (acc) next_seq++;
      @(negedge clk);
      chk("R4/R9 lq_count", lq_count, m_cnt);
      chk("R5 kill_busy", kill_busy, m_busy);
      chk("R7 blk_pending", blk_pending, m_blk);
      for (int i = 0; i < S; i++) begin
         chk("R9 ent_valid", ent_valid[i], m_val[i]);
         if (m_val[i]) begin
            chk("R2 ent_seq", ent_seq[i*SW +: SW], m_seq[i]);
            chk("R3 ent_st_idx", ent_st_idx[i*SIW +: SIW], m_sti[i]);
            chk("R3 ent_st_none", ent_st_none[i], m_stn[i]);
         end
      end
   endtask

   task automatic do_insert(int stc, int stt);
      idle_in();
      ins_valid = 1; ins_seq = SW'(next_seq); st_count = SCW'(stc); st_tail = SIW'(stt);
      step();
      idle_in();
   endtask

   task automatic drain_walk();
      idle_in();
      while (m_busy) step();
   endtask

   initial begin
      #(4 * 200000);
      chk("R5 watchdog run finished", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_head = 0; m_tail = 0; m_cnt = 0; m_busy = 0; m_blk = 0; m_num = 0; m_blkseq = 0;
      for (int i = 0; i < S; i++) begin m_val[i] = 0; m_seq[i] = 0; m_sti[i] = 0; m_stn[i] = 1; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      chk("R10 count after reset", lq_count, 0);
      chk("R10 busy after reset", kill_busy, 0);
      chk("R10 blocked after reset", blk_pending, 0);
      chk("R10 valid after reset", ent_valid, 0);
      step();

      // R1 fill to capacity, then one refused insert
      for (int i = 0; i < D + 1; i++) do_insert(i % 3, i % (SD + 1));
      chk("R1 full count held", lq_count, D);

      // R4 commit three oldest with COMMIT_W=2: two cycles, then stops
      cmt_valid = 1; cmt_seq = SW'(m_seq[m_head] + 2);
      step(); step(); step();
      idle_in();
      chk("R4 three retired", lq_count, D - 3);

      // R2 tail wrap past last slot
      for (int i = 0; i < 3; i++) do_insert(2, 5);
      chk("R2 tail wrapped count", lq_count, D);

      // R7 blocked marker survives a squash at/after it, cleared by an older one
      blk_set = 1; blk_seq = SW'(m_seq[m_head] + 1);
      step();
      idle_in();
      kill_req = 1; kill_seq = SW'(next_seq + 5);
      step();
      drain_walk();
      chk("R7 blocked kept", blk_pending, 1);
      chk("R5 nothing younger removed", lq_count, D);
      kill_req = 1; kill_seq = SW'(m_seq[m_head]);
      step();
      // R6 commit and insert ignored during the walk
      idle_in();
      cmt_valid = 1; cmt_seq = 16'hFFFF; ins_valid = 1; ins_seq = SW'(next_seq);
      step(); step();
      drain_walk();
      chk("R7 blocked cleared", blk_pending, 0);
      chk("R5/R6 only head left", lq_count, 1);

      // R5 squash everything
      kill_req = 1; kill_seq = SW'(m_seq[m_head] - 1);
      step();
      drain_walk();
      chk("R5 queue emptied", lq_count, 0);

      // constrained random mix
      for (int c = 0; c < 1500; c++) begin
         int r;
         idle_in();
         r = $urandom % 100;
         st_count = SCW'($urandom % (SD + 1));
         st_tail  = SIW'($urandom % (SD + 1));
         if (r < 55) begin ins_valid = 1; ins_seq = SW'(next_seq); end
         if (($urandom % 100) < 35) begin
            cmt_valid = 1;
            cmt_seq = (m_cnt > 0) ? SW'(m_seq[m_head] + int'($urandom % 3)) : SW'(next_seq);
         end
         if (($urandom % 100) < 6) begin
            kill_req = 1;
            kill_seq = (m_cnt > 0) ? SW'(m_seq[m_head] - 1 + int'($urandom % (m_cnt + 1)))
                                   : SW'(next_seq - 1);
         end
         if (($urandom % 100) < 5) begin
            blk_set = 1;
            blk_seq = SW'(next_seq - int'($urandom % 6));
         end
         step();
      end
      idle_in();
      step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule